// File: doc/BRIEF.md
# Weighted Random Backpressure Injector

This diagnostic block sits on three request paths inside a larger design and withdraws their ready signals at random. Stalls then happen far more often than normal traffic would cause, so the flow-control logic on each path gets exercised. Each path has its own enable bit and its own 2-bit weight code. The weight code sets what fraction of the time the path is held off.

The randomness comes from a free-running linear-feedback shift register. The register does not advance on every clock. It moves once every programmed number of clocks, and the interval is given as a count minus one. Each path latches a stall decision whenever the register advances and keeps that decision until the next advance. The decision comes from comparing a path-specific pair of register bits with the weight code. While a path is stalled, its outgoing ready is driven low. Otherwise the downstream ready passes through unchanged.

Top module: `bp_inject_top`

## Requirements
- R1: While `rst_n` is low, and after reset until the first register advance, every `up_rdy[i]` equals `dn_rdy[i]`. Reset clears all stall decisions and loads the register with the seed 16'hACE1.
- R2: When `inj_en[i]` is 0, `up_rdy[i]` equals `dn_rdy[i]` in every cycle, whatever the weight and the register state.
- R3: With weight code 0 on an enabled point, that point is stalled after every register advance, so `up_rdy[i]` is 0 from the first advance onward.
- R4: At each advance, point i latches a stall when the new register bits [2i+1:2i], read as an unsigned value, are greater than or equal to its weight code `inj_wt[2i+1:2i]`. Codes 0, 1, 2 and 3 therefore stall 4/4, 3/4, 2/4 and 1/4 of the register states.
- R5: The register is 16 bits wide. Each advance shifts it left by one and puts into bit 0 the XOR of bits 15, 13, 12 and 10. It never holds zero.
- R6: An internal clock counter starts at 0 after reset. On any clock where the count is greater than or equal to `step_ivl`, the register advances and the count returns to 0. On any other clock the count goes up by one. A stable value N therefore gives one advance every N+1 clocks, including N = 4095.
- R7: A stall decision changes only on an advance. A weight change made between advances has no effect on `up_rdy` until the next advance.
- R8: A stalled, enabled point drives `up_rdy[i]` to 0 whatever `dn_rdy[i]` is. A change of `inj_en[i]` acts on `up_rdy[i]` in the same cycle.
- R9: The three points are independent. Index 2 is the normal-memory write path, index 1 the no-zeros write path and index 0 the no-zeros read path. The weight bit pair for each point sits at the same index order as its enable bit.
- R10: With `step_ivl` equal to 0 the register advances on every clock, and the stall decisions may change on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inj_en | input | 3 | Per-point injection enable |
| inj_wt | input | 6 | Per-point 2-bit weight codes, point i at bits [2i+1:2i] |
| step_ivl | input | 12 | Register advance interval in clocks minus one |
| dn_rdy | input | 3 | Ready from downstream, one bit per point |
| up_rdy | output | 3 | Gated ready toward the requester, one bit per point |

## Verification
Two things can land in the same cycle: a register advance that changes a latched stall decision, and a change to the enable or the downstream ready that acts on the output at once. The bench provokes this with interval 0, where every clock is an advance, while the downstream-ready pattern changes each cycle and the enables change in the middle of an interval. In every cycle the output is compared against a bench model built from the polynomial, the seed, the counter rule and the threshold rule, so any error in the order of gating and latching shows up in the first cycle where the two coincide.

// File: rtl/bp_inject_pkg.sv
// Shared constants and helpers for the backpressure injector.
// Assumes: the register is wide enough to give every point its own bit pair.
package bp_inject_pkg;
    localparam int NPT    = 3;
    localparam int WT_W   = 2;
    localparam int IVL_W  = 12;
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    // Returns the feedback tap mask of a maximal-length register of width w.
    function automatic logic [31:0] tap_mask(input int w);
        case (w)
            16:      return 32'h0000_B400;
            24:      return 32'h00E1_0000;
            32:      return 32'h8020_0003;
            default: return 32'h0000_B400;
        endcase
    endfunction
endpackage

// File: rtl/bp_step_timer.sv
// Counts clocks and pulses tick once every (ivl+1) clocks.
// Assumes: ivl may change at any time; a count at or past ivl ends the interval.
module bp_step_timer #(
    parameter int IVL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IVL_W-1:0] ivl,
    output logic             tick
);
    logic [IVL_W-1:0] cnt_q;

    // Interval ends once the count reaches the programmed limit.
    assign tick = (cnt_q >= ivl);

    // Count up between ticks; restart at zero on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R6: after a tick the count restarts from zero.
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));
    // R10: a zero interval ticks on every clock.
    p_every_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl == '0) |-> tick);
endmodule

// File: rtl/bp_lfsr.sv
// Fibonacci shift register that advances only when adv is high.
// Assumes: the seed is nonzero, so the all-zero state is never entered.
module bp_lfsr
    import bp_inject_pkg::*;
#(
    parameter int          W    = 16,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] state
);
    localparam logic [W-1:0] MASK = W'(tap_mask(W));

    logic [W-1:0] st_q;
    logic         fb;

    // Feedback bit is the parity of the tapped positions.
    assign fb = ^(st_q & MASK);

    // Shift in the feedback bit on each advance; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)   st_q <= SEED;
        else if (adv) st_q <= {st_q[W-2:0], fb};
    end

    assign state = st_q;

    // R5: the register never holds zero.
    p_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != '0);
    // R6: without an advance the register holds still.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(st_q));
endmodule

// File: rtl/bp_stall_point.sv
// One injection point: latches a stall decision on each advance and gates ready.
// Assumes: rnd is the register value that becomes current on the tick edge.
module bp_stall_point #(
    parameter int WT_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [WT_W-1:0] rnd,
    input  logic [WT_W-1:0] wt,
    input  logic            en,
    input  logic            dn,
    output logic            up
);
    logic stall_q;

    // Latch the threshold comparison on every advance; hold in between.
    always_ff @(posedge clk) begin
        if (!rst_n)    stall_q <= 1'b0;
        else if (tick) stall_q <= (rnd >= wt);
    end

    // Withdraw ready while an enabled point is stalled.
    assign up = dn & ~(en & stall_q);

    // R3: weight code 0 stalls after every advance.
    p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wt == '0) |=> stall_q);
    // R7: the decision holds between advances.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(stall_q));
    // R8: an enabled, stalled point never shows ready.
    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stall_q) |-> !up);
    // R2: a disabled point passes downstream ready straight through.
    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (up == dn));
endmodule

// File: rtl/bp_inject_top.sv
// Weighted random backpressure injector for three request points.
// Assumes: point 2 = normal writes, 1 = no-zeros writes, 0 = no-zeros reads.
module bp_inject_top
    import bp_inject_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPT-1:0]        inj_en,
    input  logic [NPT*WT_W-1:0]   inj_wt,
    input  logic [IVL_W-1:0]      step_ivl,
    input  logic [NPT-1:0]        dn_rdy,
    output logic [NPT-1:0]        up_rdy
);
    localparam int PAIR_BITS = NPT * WT_W;

    logic              tick;
    logic [LFSR_W-1:0] rnd_now;
    logic [LFSR_W-1:0] rnd_next;

    // Each point needs a bit pair of its own.
    if (PAIR_BITS > LFSR_W) begin : g_bad_width
        initial $error("register too narrow for the points");
    end

    bp_step_timer #(.IVL_W(IVL_W)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ivl   (step_ivl),
        .tick  (tick)
    );

    bp_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) lfsr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (tick),
        .state (rnd_now)
    );

    // Value the register takes on the next advance, so decisions match it.
    assign rnd_next = {rnd_now[LFSR_W-2:0], ^(rnd_now & LFSR_W'(tap_mask(LFSR_W)))};

    for (genvar i = 0; i < NPT; i++) begin : g_pt
        bp_stall_point #(.WT_W(WT_W)) pt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .rnd   (rnd_next[i*WT_W +: WT_W]),
            .wt    (inj_wt[i*WT_W +: WT_W]),
            .en    (inj_en[i]),
            .dn    (dn_rdy[i]),
            .up    (up_rdy[i])
        );

        // R9: an output never shows ready that downstream did not give.
        p_no_invent_r9: assert property (@(posedge clk) disable iff (!rst_n)
            up_rdy[i] |-> dn_rdy[i]);
    end
endmodule

// File: tb/bp_inject_top_tb_top.sv
// Table-driven bench with a cycle-exact reference model of the injector.
module bp_inject_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  inj_en = '0;
    logic [5:0]  inj_wt = '0;
    logic [11:0] step_ivl = '0;
    logic [2:0]  dn_rdy = '0;
    logic [2:0]  up_rdy;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] m_lfsr = 16'hACE1;
    int          m_cnt = 0;
    logic [2:0]  m_stall = '0;

    always #5 clk = ~clk;

    bp_inject_top dut_i (
        .clk(clk), .rst_n(rst_n), .inj_en(inj_en), .inj_wt(inj_wt),
        .step_ivl(step_ivl), .dn_rdy(dn_rdy), .up_rdy(up_rdy)
    );

    // Entry: en[3], wt[6], ivl[12], cycles[12], tag[4]
    localparam int NE = 10;
    localparam logic [36:0] TBL [NE] = '{
        {3'b000, 6'b00_00_00, 12'd3,  12'd80,  4'd2},
        {3'b111, 6'b00_00_00, 12'd1,  12'd60,  4'd3},
        {3'b111, 6'b11_10_01, 12'd2,  12'd300, 4'd4},
        {3'b101, 6'b01_00_11, 12'd0,  12'd200, 4'd10},
        {3'b111, 6'b10_10_10, 12'd7,  12'd400, 4'd6},
        {3'b010, 6'b00_01_10, 12'd5,  12'd150, 4'd9},
        {3'b111, 6'b00_00_00, 12'd30, 12'd25,  4'd7},
        {3'b111, 6'b11_11_11, 12'd30, 12'd70,  4'd7},
        {3'b000, 6'b11_11_11, 12'd30, 12'd20,  4'd8},
        {3'b111, 6'b01_01_01, 12'd0,  12'd500, 4'd5}
    };

    function automatic string tag_of(input logic [3:0] t);
        case (t)
            4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
            4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
            4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Register step from R5: shift left, feed back parity of bits 15,13,12,10.
    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [2:0] expect_up();
        logic [2:0] e;
        for (int i = 0; i < 3; i++) e[i] = dn_rdy[i] & ~(inj_en[i] & m_stall[i]);
        return e;
    endfunction

    // Model update at a clock edge, from R1, R4, R5 and R6.
    task automatic model_edge();
        if (!rst_n) begin
            m_lfsr = 16'hACE1; m_cnt = 0; m_stall = '0;
        end else if (m_cnt >= int'(step_ivl)) begin
            m_cnt = 0;
            m_lfsr = lfsr_step(m_lfsr);
            for (int i = 0; i < 3; i++)
                m_stall[i] = (m_lfsr[2*i +: 2] >= inj_wt[2*i +: 2]);
        end else begin
            m_cnt = m_cnt + 1;
        end
    endtask

    task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: up_rdy=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Runs n cycles, varying downstream ready, checking every cycle.
    task automatic run(input int n, input string tag);
        for (int c = 0; c < n; c++) begin
            dn_rdy = 3'b111 ^ 3'(c % 8);
            #1;
            check(up_rdy, expect_up(), tag);
            @(posedge clk);
            model_edge();
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: held in reset with full-stall settings, outputs follow downstream.
        inj_en = 3'b111; inj_wt = '0; step_ivl = 12'd10;
        run(4, "R1");
        rst_n = 1'b1;
        // R1: released, no stall before the first advance.
        run(10, "R1");
        for (int k = 0; k < NE; k++) begin
            {inj_en, inj_wt, step_ivl} = TBL[k][36:16];
            run(int'(TBL[k][15:4]), tag_of(TBL[k][3:0]));
        end
        // R3: weight 0 on all points, downstream ready high, outputs all low.
        inj_en = 3'b111; inj_wt = '0; step_ivl = 12'd0;
        @(posedge clk); model_edge(); @(negedge clk);
        dn_rdy = 3'b111; #1;
        check(up_rdy, 3'b000, "R3");
        @(posedge clk); model_edge(); @(negedge clk);
        // R6: largest interval, two full periods.
        inj_wt = 6'b10_01_00; step_ivl = 12'd4095;
        run(8200, "R6");
        // R1: reset in mid-run clears stalls.
        rst_n = 1'b0; inj_wt = '0; step_ivl = 12'd0;
        run(3, "R1");
        rst_n = 1'b1; step_ivl = 12'd6;
        run(4, "R1");
        // R8: enable change acts in the same cycle while stalled.
        run(20, "R8");
        inj_en = 3'b000;
        run(5, "R8");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule